// File: doc/BRIEF.md
# Netlist Controllability Number Engine

This block computes four testability figures for every node of a small gate-level netlist that is held inside it. The figures are the combinational cost of driving a node to 0 and to 1 (cc0, cc1) and the number of time frames needed to do so (sc0, sc1). Each netlist entry is written through a valid/ready load port. An entry holds a node kind, a width bit, and up to three fanin indices.

A one-cycle `start` pulse seeds the figures. The engine then walks the table from node 0 to node NODES-1, one node per clock, and recomputes each node from the current figures of its fanins. The new value is written back at once, so later nodes in the same sweep see it. Sweeps repeat until a whole sweep leaves every figure unchanged. `done` then rises. If the sweep limit is reached first, `done` rises together with `err`. Any node's figures can be read at any time through a combinational read port.

Load port rules: a word transfers on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is low for the whole time the engine is busy. A word offered while `ld_ready` is low is not stored, so the source must keep it until `ld_ready` returns.

Top module: `cnum_engine`

## Requirements
- R1: After reset, busy, done and err are 0, ld_ready is 1, every table entry is kind 0, and every figure reads back as 255.
- R2: A table word is stored only on an edge where ld_valid and ld_ready are both 1. ld_ready equals the inverse of busy, and words offered while busy leave the table unchanged.
- R3: Figures are 8-bit unsigned and 255 means infinity. A sum that has an infinite operand, or that reaches 255 or more, yields 255.
- R4: On start, nodes of kind 0 (primary input; kinds 6 and 7 are treated the same way) get 1 in all four figures and keep it. Every other node gets 255.
- R5: Kind 1 (AND) reads fanin a and fanin b, plus fanin c when the wide bit is 1. cc1 = sum of the input cc1 values + 1. cc0 = minimum input cc0 + 1. sc1 = sum of the input sc1 values. sc0 = minimum input sc0. A fanin that is not used has no effect.
- R6: Kind 2 (OR) has the same inputs as R5 with 0 and 1 exchanged. cc0 = sum of input cc0 + 1. cc1 = minimum input cc1 + 1. sc0 = sum of input sc0. sc1 = minimum input sc1.
- R7: Kind 3 (XOR) uses fanins a and b. cc0 = min(a0+b0, a1+b1) + 1 and cc1 = min(a0+b1, a1+b0) + 1. The sc figures are formed the same way from sc values, with no +1.
- R8: Kind 4 (inverter) uses fanin a. cc0 = a.cc1 + 1, cc1 = a.cc0 + 1, sc0 = a.sc1 and sc1 = a.sc0.
- R9: Kind 5 (D flip-flop) takes fanin a as its active-low reset R, b as data D and c as clock C, with K = C0 + C1. cc0 = min(R0, R1+D0+K) and cc1 = R1+D1+K, with no +1. sc0 and sc1 use the same formulas on sc values, each plus 1.
- R10: Each sweep visits nodes 0 to NODES-1 in order and updates in place. The run stops after the first sweep with no change. done rises exactly sweeps×NODES cycles after the start edge.
- R11: If sweep number NODES+1 still changes a figure, the run stops at the end of that sweep with done and err both 1. err is cleared by the next start.
- R12: start while busy is ignored. An accepted start clears done and err and sets busy on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Table write word valid |
| ld_ready | output | 1 | Table can accept a word (engine idle) |
| ld_idx | input | IW | Node index to write |
| ld_kind | input | 3 | Node kind code |
| ld_wide | input | 1 | AND/OR uses fanin c as a third input |
| ld_fa | input | IW | Fanin a index |
| ld_fb | input | IW | Fanin b index |
| ld_fc | input | IW | Fanin c index |
| start | input | 1 | Begin a computation (one-cycle pulse) |
| busy | output | 1 | Sweeps in progress |
| done | output | 1 | Last run finished; held until next start |
| err | output | 1 | Last run hit the sweep limit |
| rd_idx | input | IW | Node index to read back |
| rd_cc0 | output | 8 | Combinational 0-controllability of rd_idx |
| rd_cc1 | output | 8 | Combinational 1-controllability of rd_idx |
| rd_sc0 | output | 8 | Sequential 0-controllability of rd_idx |
| rd_sc1 | output | 8 | Sequential 1-controllability of rd_idx |

## Verification
The bench targets the following corner cases:
- A three-input AND chain that overflows 8 bits. A design that wrapped its sums would report small numbers where 255 is due.
- A two-input AND whose unused fanin c points at a node stuck at infinity. A design that did not ignore that fanin would saturate the result.
- An inverter ring closed by an AND. The ring needs more sweeps than the limit allows, so a design that mishandled the limit would either hang or stop with the wrong partial figures and no err.
- A start pulse and a table write offered mid-run. A design that accepted either would change the sweep count or the final figures.

Random netlists with forward references, self loops and flip-flop feedback check the in-place update order. A design that updated from the previous sweep's values would finish after a different number of cycles.

// File: rtl/cnum_pkg.sv
package cnum_pkg;
  localparam int unsigned VAL_W = 8;
  localparam logic [VAL_W-1:0] INF = {VAL_W{1'b1}};
  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  localparam logic [2:0] K_PI  = 3'd0;
  localparam logic [2:0] K_AND = 3'd1;
  localparam logic [2:0] K_OR  = 3'd2;
  localparam logic [2:0] K_XOR = 3'd3;
  localparam logic [2:0] K_INV = 3'd4;
  localparam logic [2:0] K_DFF = 3'd5;

  typedef struct packed {
    logic [VAL_W-1:0] cc0;
    logic [VAL_W-1:0] cc1;
    logic [VAL_W-1:0] sc0;
    logic [VAL_W-1:0] sc1;
  } num_t;

  function automatic logic [VAL_W-1:0] sat_add(input logic [VAL_W-1:0] a,
                                               input logic [VAL_W-1:0] b);
    logic [VAL_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (a == INF || b == INF || s >= {1'b0, INF}) return INF;
    return s[VAL_W-1:0];
  endfunction

  function automatic logic [VAL_W-1:0] min2(input logic [VAL_W-1:0] a,
                                            input logic [VAL_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/cnum_netlist.sv
module cnum_netlist
  import cnum_pkg::*;
#(
  parameter int unsigned NODES = 16,
  localparam int unsigned IW = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [2:0]       wr_kind,
  input  logic             wr_wide,
  input  logic [IW-1:0]    wr_fa,
  input  logic [IW-1:0]    wr_fb,
  input  logic [IW-1:0]    wr_fc,
  input  logic [IW-1:0]    sel,
  output logic [2:0]       sel_kind,
  output logic             sel_wide,
  output logic [IW-1:0]    sel_fa,
  output logic [IW-1:0]    sel_fb,
  output logic [IW-1:0]    sel_fc,
  output logic [NODES-1:0] pi_mask
);
  logic [2:0]    kind_q [NODES];
  logic          wide_q [NODES];
  logic [IW-1:0] fa_q   [NODES];
  logic [IW-1:0] fb_q   [NODES];
  logic [IW-1:0] fc_q   [NODES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) begin
        kind_q[i] <= K_PI;
        wide_q[i] <= 1'b0;
        fa_q[i]   <= '0;
        fb_q[i]   <= '0;
        fc_q[i]   <= '0;
      end
    end else if (wr_en) begin
      kind_q[wr_idx] <= wr_kind;
      wide_q[wr_idx] <= wr_wide;
      fa_q[wr_idx]   <= wr_fa;
      fb_q[wr_idx]   <= wr_fb;
      fc_q[wr_idx]   <= wr_fc;
    end
  end

  assign sel_kind = kind_q[sel];
  assign sel_wide = wide_q[sel];
  assign sel_fa   = fa_q[sel];
  assign sel_fb   = fb_q[sel];
  assign sel_fc   = fc_q[sel];

  for (genvar g = 0; g < NODES; g++) begin : g_pi
    assign pi_mask[g] = (kind_q[g] == K_PI) || (kind_q[g] > K_DFF);
  end
endmodule

// File: rtl/cnum_rule.sv
module cnum_rule
  import cnum_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       wide,
  input  num_t       va,
  input  num_t       vb,
  input  num_t       vc,
  output num_t       nv
);
  logic [VAL_W-1:0] clk_c, clk_s, r_c1, r_s1;

  always_comb begin
    nv    = '{cc0: ONE, cc1: ONE, sc0: ONE, sc1: ONE};
    clk_c = sat_add(vc.cc0, vc.cc1);
    clk_s = sat_add(vc.sc0, vc.sc1);
    r_c1  = sat_add(va.cc1, clk_c);
    r_s1  = sat_add(va.sc1, clk_s);
    case (kind)
      K_AND: begin
        nv.cc1 = sat_add(sat_add(sat_add(va.cc1, vb.cc1), wide ? vc.cc1 : '0), ONE);
        nv.cc0 = sat_add(min2(min2(va.cc0, vb.cc0), wide ? vc.cc0 : INF), ONE);
        nv.sc1 = sat_add(sat_add(va.sc1, vb.sc1), wide ? vc.sc1 : '0);
        nv.sc0 = min2(min2(va.sc0, vb.sc0), wide ? vc.sc0 : INF);
      end
      K_OR: begin
        nv.cc0 = sat_add(sat_add(sat_add(va.cc0, vb.cc0), wide ? vc.cc0 : '0), ONE);
        nv.cc1 = sat_add(min2(min2(va.cc1, vb.cc1), wide ? vc.cc1 : INF), ONE);
        nv.sc0 = sat_add(sat_add(va.sc0, vb.sc0), wide ? vc.sc0 : '0);
        nv.sc1 = min2(min2(va.sc1, vb.sc1), wide ? vc.sc1 : INF);
      end
      K_XOR: begin
        nv.cc0 = sat_add(min2(sat_add(va.cc0, vb.cc0), sat_add(va.cc1, vb.cc1)), ONE);
        nv.cc1 = sat_add(min2(sat_add(va.cc0, vb.cc1), sat_add(va.cc1, vb.cc0)), ONE);
        nv.sc0 = min2(sat_add(va.sc0, vb.sc0), sat_add(va.sc1, vb.sc1));
        nv.sc1 = min2(sat_add(va.sc0, vb.sc1), sat_add(va.sc1, vb.sc0));
      end
      K_INV: begin
        nv.cc0 = sat_add(va.cc1, ONE);
        nv.cc1 = sat_add(va.cc0, ONE);
        nv.sc0 = va.sc1;
        nv.sc1 = va.sc0;
      end
      K_DFF: begin
        nv.cc0 = min2(va.cc0, sat_add(r_c1, vb.cc0));
        nv.cc1 = sat_add(r_c1, vb.cc1);
        nv.sc0 = sat_add(min2(va.sc0, sat_add(r_s1, vb.sc0)), ONE);
        nv.sc1 = sat_add(sat_add(r_s1, vb.sc1), ONE);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cnum_sweep.sv
module cnum_sweep
  import cnum_pkg::*;
#(
  parameter int unsigned NODES = 16,
  localparam int unsigned IW    = $clog2(NODES),
  localparam int unsigned LIMIT = NODES + 1,
  localparam int unsigned SW_W  = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NODES-1:0] pi_mask,
  input  logic [2:0]       kind,
  input  logic [IW-1:0]    fa,
  input  logic [IW-1:0]    fb,
  input  logic [IW-1:0]    fc,
  input  num_t             nv,
  input  logic [IW-1:0]    rd_idx,
  output logic [IW-1:0]    cur,
  output num_t             va,
  output num_t             vb,
  output num_t             vc,
  output num_t             rd_val,
  output logic             busy,
  output logic             done,
  output logic             err
);
  num_t            vals [NODES];
  logic [SW_W-1:0] sweeps;
  logic            chg;
  logic            chg_now;
  logic            last;

  assign va      = vals[fa];
  assign vb      = vals[fb];
  assign vc      = vals[fc];
  assign rd_val  = vals[rd_idx];
  assign chg_now = chg || (nv != vals[cur]);
  assign last    = (cur == IW'(NODES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      cur    <= '0;
      sweeps <= '0;
      chg    <= 1'b0;
      for (int i = 0; i < NODES; i++) vals[i] <= '{cc0: INF, cc1: INF, sc0: INF, sc1: INF};
    end else if (start && !busy) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      err    <= 1'b0;
      cur    <= '0;
      sweeps <= '0;
      chg    <= 1'b0;
      for (int i = 0; i < NODES; i++)
        vals[i] <= pi_mask[i] ? '{cc0: ONE, cc1: ONE, sc0: ONE, sc1: ONE}
                              : '{cc0: INF, cc1: INF, sc0: INF, sc1: INF};
    end else if (busy) begin
      vals[cur] <= nv;
      if (last) begin
        cur <= '0;
        chg <= 1'b0;
        if (!chg_now) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (sweeps == SW_W'(LIMIT - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          err  <= 1'b1;
        end else begin
          sweeps <= sweeps + 1'b1;
        end
      end else begin
        cur <= cur + 1'b1;
        chg <= chg_now;
      end
    end
  end

  // R10: figures never grow during a run
  p_monotone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (nv.cc0 <= vals[cur].cc0 && nv.cc1 <= vals[cur].cc1 &&
              nv.sc0 <= vals[cur].sc0 && nv.sc1 <= vals[cur].sc1));

  // R4: seeded inputs keep 1 in every figure while sweeping
  p_pi_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pi_mask[cur]) |-> (vals[cur] == '{cc0: ONE, cc1: ONE, sc0: ONE, sc1: ONE}));

  // R3: infinity on an AND input cc1 saturates the output
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == K_AND && va.cc1 == INF) |-> nv.cc1 == INF);

  // R11: err is only seen with done
  p_err_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !busy));

  // R12: accepted start gives busy with done and err cleared
  p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !err));
endmodule

// File: rtl/cnum_engine.sv
module cnum_engine
  import cnum_pkg::*;
#(
  parameter int unsigned NODES = 16,
  localparam int unsigned IW = $clog2(NODES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [IW-1:0]         ld_idx,
  input  logic [2:0]            ld_kind,
  input  logic                  ld_wide,
  input  logic [IW-1:0]         ld_fa,
  input  logic [IW-1:0]         ld_fb,
  input  logic [IW-1:0]         ld_fc,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  input  logic [IW-1:0]         rd_idx,
  output logic [VAL_W-1:0]      rd_cc0,
  output logic [VAL_W-1:0]      rd_cc1,
  output logic [VAL_W-1:0]      rd_sc0,
  output logic [VAL_W-1:0]      rd_sc1
);
  logic [IW-1:0]    cur, fa, fb, fc;
  logic [2:0]       kind;
  logic             wide;
  logic [NODES-1:0] pi_mask;
  num_t             va, vb, vc, nv, rd_val;

  assign ld_ready = !busy;

  cnum_netlist #(.NODES(NODES)) u_netlist (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_valid && ld_ready), .wr_idx(ld_idx),
    .wr_kind(ld_kind), .wr_wide(ld_wide), .wr_fa(ld_fa), .wr_fb(ld_fb), .wr_fc(ld_fc),
    .sel(cur), .sel_kind(kind), .sel_wide(wide), .sel_fa(fa), .sel_fb(fb), .sel_fc(fc),
    .pi_mask(pi_mask)
  );

  cnum_rule u_rule (
    .kind(kind), .wide(wide), .va(va), .vb(vb), .vc(vc), .nv(nv)
  );

  cnum_sweep #(.NODES(NODES)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(start), .pi_mask(pi_mask), .kind(kind),
    .fa(fa), .fb(fb), .fc(fc), .nv(nv), .rd_idx(rd_idx), .cur(cur),
    .va(va), .vb(vb), .vc(vc), .rd_val(rd_val), .busy(busy), .done(done), .err(err)
  );

  assign rd_cc0 = rd_val.cc0;
  assign rd_cc1 = rd_val.cc1;
  assign rd_sc0 = rd_val.sc0;
  assign rd_sc1 = rd_val.sc1;

  // R2: no table word is taken while sweeping
  p_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready);
endmodule

// File: tb/cnum_engine_bench.sv
module cnum_engine_bench;
  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0, ld_wide = 1'b0, start = 1'b0;
  logic          ld_ready, busy, done, err;
  logic [IW-1:0] ld_idx = '0, ld_fa = '0, ld_fb = '0, ld_fc = '0, rd_idx = '0;
  logic [2:0]    ld_kind = '0;
  logic [7:0]    rd_cc0, rd_cc1, rd_sc0, rd_sc1;

  always #5 clk = ~clk;

  cnum_engine #(.NODES(N)) u_cnum_engine (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_idx(ld_idx), .ld_kind(ld_kind), .ld_wide(ld_wide), .ld_fa(ld_fa),
    .ld_fb(ld_fb), .ld_fc(ld_fc), .start(start), .busy(busy), .done(done),
    .err(err), .rd_idx(rd_idx), .rd_cc0(rd_cc0), .rd_cc1(rd_cc1),
    .rd_sc0(rd_sc0), .rd_sc1(rd_sc1)
  );

  int m_kind[N], m_w[N], m_a[N], m_b[N], m_c[N];
  int ev[N][4];
  int exp_sw, exp_err;
  int n_chk = 0, n_fail = 0, wd = 0;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected<=150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int expv, input string what);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic int sadd(input int a, input int b);
    return (a >= 255 || b >= 255 || a + b >= 255) ? 255 : a + b;
  endfunction
  function automatic int smin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
  function automatic string ktag(input int k);
    case (k)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic model_node(input int i, output int n0, output int n1, output int n2, output int n3);
    int a0, a1, a2, a3, b0, b1, b2, b3, c0, c1, c2, c3, kc, ks;
    a0 = ev[m_a[i]][0]; a1 = ev[m_a[i]][1]; a2 = ev[m_a[i]][2]; a3 = ev[m_a[i]][3];
    b0 = ev[m_b[i]][0]; b1 = ev[m_b[i]][1]; b2 = ev[m_b[i]][2]; b3 = ev[m_b[i]][3];
    c0 = ev[m_c[i]][0]; c1 = ev[m_c[i]][1]; c2 = ev[m_c[i]][2]; c3 = ev[m_c[i]][3];
    n0 = 1; n1 = 1; n2 = 1; n3 = 1;
    case (m_kind[i])
      1: begin
        n1 = sadd(sadd(sadd(a1, b1), m_w[i] ? c1 : 0), 1);
        n0 = sadd(smin(smin(a0, b0), m_w[i] ? c0 : 255), 1);
        n3 = sadd(sadd(a3, b3), m_w[i] ? c3 : 0);
        n2 = smin(smin(a2, b2), m_w[i] ? c2 : 255);
      end
      2: begin
        n0 = sadd(sadd(sadd(a0, b0), m_w[i] ? c0 : 0), 1);
        n1 = sadd(smin(smin(a1, b1), m_w[i] ? c1 : 255), 1);
        n2 = sadd(sadd(a2, b2), m_w[i] ? c2 : 0);
        n3 = smin(smin(a3, b3), m_w[i] ? c3 : 255);
      end
      3: begin
        n0 = sadd(smin(sadd(a0, b0), sadd(a1, b1)), 1);
        n1 = sadd(smin(sadd(a0, b1), sadd(a1, b0)), 1);
        n2 = smin(sadd(a2, b2), sadd(a3, b3));
        n3 = smin(sadd(a2, b3), sadd(a3, b2));
      end
      4: begin
        n0 = sadd(a1, 1); n1 = sadd(a0, 1); n2 = a3; n3 = a2;
      end
      5: begin
        kc = sadd(c0, c1); ks = sadd(c2, c3);
        n0 = smin(a0, sadd(sadd(a1, b0), kc));
        n1 = sadd(sadd(a1, b1), kc);
        n2 = sadd(smin(a2, sadd(sadd(a3, b2), ks)), 1);
        n3 = sadd(sadd(sadd(a3, b3), ks), 1);
      end
      default: ;
    endcase
  endtask

  task automatic model_run();
    int n0, n1, n2, n3;
    bit ch;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < 4; j++)
        ev[i][j] = (m_kind[i] == 0 || m_kind[i] > 5) ? 1 : 255;
    for (int k = 1; k <= N + 1; k++) begin
      ch = 0;
      for (int i = 0; i < N; i++) begin
        model_node(i, n0, n1, n2, n3);
        if (n0 != ev[i][0] || n1 != ev[i][1] || n2 != ev[i][2] || n3 != ev[i][3]) ch = 1;
        ev[i][0] = n0; ev[i][1] = n1; ev[i][2] = n2; ev[i][3] = n3;
      end
      exp_sw = k;
      exp_err = (ch && k == N + 1) ? 1 : 0;
      if (!ch) break;
    end
  endtask

  task automatic load(input int idx, input int k, input int w, input int a, input int b, input int c);
    @(negedge clk);
    ld_valid = 1'b1; ld_idx = IW'(idx); ld_kind = 3'(k); ld_wide = w[0];
    ld_fa = IW'(a); ld_fb = IW'(b); ld_fc = IW'(c);
    @(negedge clk);
    ld_valid = 1'b0;
    m_kind[idx] = k; m_w[idx] = w; m_a[idx] = a; m_b[idx] = b; m_c[idx] = c;
  endtask

  task automatic run_check(input string tag, input bit poke);
    int cyc;
    model_run();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12", {29'd0, busy, done, err}, 32'b100, "busy/done/err after start");
    cyc = 0;
    while (!done && cyc < 2000) begin
      if (poke && cyc == 2) begin
        chk("R2", {31'd0, ld_ready}, 0, "ld_ready while busy");
        start = 1'b1;
        ld_valid = 1'b1; ld_idx = '0; ld_kind = 3'd4; ld_fa = 4'd1;
      end
      if (poke && cyc == 3) begin
        start = 1'b0; ld_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    chk("R10", cyc, exp_sw * N, "cycles from start to done");
    chk("R11", {31'd0, err}, exp_err, "err flag");
    for (int i = 0; i < N; i++) begin
      rd_idx = IW'(i);
      #1;
      chk((tag == "") ? ktag(m_kind[i]) : tag, {rd_cc0, rd_cc1, rd_sc0, rd_sc1},
          {ev[i][0][7:0], ev[i][1][7:0], ev[i][2][7:0], ev[i][3][7:0]},
          $sformatf("node %0d figures", i));
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < N; i++) begin
      m_kind[i] = 0; m_w[i] = 0; m_a[i] = 0; m_b[i] = 0; m_c[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {28'd0, busy, done, err, ld_ready}, 32'b0001, "flags after reset");
    for (int i = 0; i < N; i += 5) begin
      rd_idx = IW'(i);
      #1;
      chk("R1", {rd_cc0, rd_cc1, rd_sc0, rd_sc1}, 32'hFFFF_FFFF, "figures after reset");
    end

    // Directed mix: XOR, narrow AND with an infinite c, OR3, flip-flop, inverter
    load(2, 3, 0, 0, 1, 0);
    load(3, 1, 0, 0, 1, 5);
    load(5, 4, 0, 5, 0, 0);
    load(4, 2, 1, 0, 1, 2);
    load(6, 5, 0, 0, 2, 1);
    load(7, 4, 0, 6, 0, 0);
    load(8, 5, 0, 0, 9, 1);
    load(9, 4, 0, 8, 0, 0);
    load(10, 6, 0, 0, 0, 0);
    run_check("", 1'b0);
    rd_idx = 4'd3; #1;
    chk("R5", {rd_cc0, rd_cc1, rd_sc0, rd_sc1}, 32'h02030102, "AND unused fanin c ignored");
    rd_idx = 4'd2; #1;
    chk("R7", {rd_cc0, rd_cc1, rd_sc0, rd_sc1}, 32'h03030202, "XOR of two inputs");
    rd_idx = 4'd6; #1;
    chk("R9", {rd_cc0, rd_cc1, rd_sc0, rd_sc1}, 32'h01060206, "flip-flop figures");

    // Start and a table write offered while busy are ignored
    run_check("", 1'b1);

    // R3: three-input AND chain overflows
    for (int i = 0; i < N; i++) load(i, 0, 0, 0, 0, 0);
    for (int i = 1; i < 8; i++) load(i, 1, 1, i - 1, i - 1, i - 1);
    run_check("R3", 1'b0);
    rd_idx = 4'd5; #1;
    chk("R3", {24'd0, rd_cc1}, 255, "saturated cc1");

    // R11: inverter ring closed by an AND needs more than the limit
    load(0, 0, 0, 0, 0, 0);
    load(1, 0, 0, 0, 0, 0);
    for (int i = 2; i < N - 1; i++) load(i, 4, 0, i + 1, 0, 0);
    load(N - 1, 1, 0, 2, 0, 0);
    run_check("R11", 1'b0);
    chk("R11", exp_err, 1, "limit scenario expected");

    // Random netlists
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < N; i++) begin
        int k, a, b, c;
        k = (i < 2) ? 0 : $urandom_range(0, 7);
        a = (i > 0 && $urandom_range(0, 9) < 8) ? $urandom_range(0, i - 1) : $urandom_range(0, N - 1);
        b = (i > 0 && $urandom_range(0, 9) < 8) ? $urandom_range(0, i - 1) : $urandom_range(0, N - 1);
        c = (i > 0 && $urandom_range(0, 9) < 8) ? $urandom_range(0, i - 1) : $urandom_range(0, N - 1);
        load(i, k, $urandom_range(0, 1), a, b, c);
      end
      run_check("", t == 7);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule